// File: doc/BRIEF.md
# Card Presence Interrupt Controller

This block watches the presence line of a removable memory card and turns its changes into interrupts. The presence, busy and write-protect lines come from the card socket, so they are brought into the clock domain through a two-flop synchronizer. A rising edge of the synchronized presence line is an insert event (the card is now present). A falling edge is a remove event (the card is now gone).

Software drives the block through a small register port with three registers. The arming register holds an insert arm bit, a remove arm bit and a master gate. The pending register records armed events, and software clears a bit in it by writing a one to that bit. The socket register reports the synchronized socket lines. The intended use is that software arms only the event opposite to the current presence state. When a card is present, it arms remove. When the socket is empty, it arms insert. An event whose arm bit is clear is not recorded. The interrupt line is the master gate ANDed with the OR of each pending bit ANDed with its own arm bit.

Register map (word addresses): 0 is the arming register, with bit 0 insert arm, bit 1 remove arm and bit 2 master gate. 1 is the pending register, with bit 0 insert and bit 1 remove. 2 is the socket register, with bit 0 present, bit 1 busy and bit 2 write-protect. Reads return the register on the same cycle. Unused bits and address 3 read as zero.

Top module: `cdi_ctrl`

## Requirements
- R1: After reset the arming register, the pending register and `irq_o` are all zero.
- R2: A write to address 0 loads bits [2:0] into the arming register. A read of address 0 returns them, with zeros in bits [7:3]. No other address changes the arming register.
- R3: A rising edge of `card_present_i` sets pending bit 0 only when arm bit 0 is set. When arm bit 0 is clear, the edge leaves the pending register unchanged.
- R4: A falling edge of `card_present_i` sets pending bit 1 only when arm bit 1 is set. When arm bit 1 is clear, the edge leaves the pending register unchanged.
- R5: A write to address 1 clears each pending bit whose write-data bit is one and leaves the pending bits whose write-data bit is zero.
- R6: If an armed event and a clearing write to the same pending bit fall in the same cycle, the bit ends up set.
- R7: `irq_o` is high exactly when arm bit 2 is set and some pending bit is set while its own arm bit is set. Dropping the master gate lowers `irq_o` and leaves the pending bits unchanged.
- R8: Address 2 reads the synchronized socket lines: bit 0 present, bit 1 busy, bit 2 write-protect.
- R9: A write to address 2 changes neither the arming register nor the pending register.
- R10: Writing 0 to address 0 and then 3 to address 1 leaves `irq_o` low and the pending register zero.
- R11: A presence change made between two clock edges shows in the pending register after the third following rising edge and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_present_i | input | 1 | Socket presence line, asynchronous |
| card_busy_i | input | 1 | Card busy line, asynchronous |
| card_ro_i | input | 1 | Write-protect line, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The checker covers the following on every cycle:
- a pending bit rises only when its arm bit was set one cycle earlier;
- a clearing write with no competing event empties the bit;
- the arming register moves only on a write to its own address;
- a write to the socket register disturbs no state;
- the interrupt line stays low while the master gate is off.

Only the directed scenarios can show the rest:
- the exact three-edge latency from the socket line to the pending register;
- the set-over-clear race;
- an unarmed edge being dropped;
- the socket readback of busy and write-protect.

// File: rtl/cdi_pkg.sv
package cdi_pkg;
  localparam int unsigned REG_ARM  = 0;
  localparam int unsigned REG_PEND = 1;
  localparam int unsigned REG_SOCK = 2;

  localparam int unsigned ARM_INS = 0;
  localparam int unsigned ARM_REM = 1;
  localparam int unsigned ARM_GLB = 2;
  localparam int unsigned ARM_W   = 3;

  localparam int unsigned EVT_W   = 2;

  localparam int unsigned SOCK_PRES = 0;
  localparam int unsigned SOCK_BUSY = 1;
  localparam int unsigned SOCK_RO   = 2;
  localparam int unsigned SOCK_W    = 3;

  typedef struct packed {
    logic rem;
    logic ins;
  } evt_t;
endpackage

// File: rtl/cdi_sync.sv
module cdi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cdi_edge.sv
module cdi_edge
  import cdi_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output evt_t evt_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  // insert = now present, remove = now absent
  assign evt_o.ins = level_i & ~prev_q;
  assign evt_o.rem = ~level_i & prev_q;
endmodule

// File: rtl/cdi_regs.sv
module cdi_regs
  import cdi_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  evt_t              evt_i,
  input  logic [SOCK_W-1:0] sock_i,
  output logic [ARM_W-1:0]  arm_o,
  output logic [EVT_W-1:0]  pend_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [ARM_W-1:0] arm_q;
  logic [EVT_W-1:0] pend_q, set_v, clr_v;
  logic             wr_arm, wr_pend;

  assign wr_arm  = we_i && (addr_i == ADDR_W'(REG_ARM));
  assign wr_pend = we_i && (addr_i == ADDR_W'(REG_PEND));

  assign set_v[ARM_INS] = evt_i.ins & arm_q[ARM_INS];
  assign set_v[ARM_REM] = evt_i.rem & arm_q[ARM_REM];
  assign clr_v          = wr_pend ? wdata_i[EVT_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      pend_q <= '0;
    end else begin
      if (wr_arm) arm_q <= wdata_i[ARM_W-1:0];
      pend_q <= (pend_q & ~clr_v) | set_v;  // set beats clear
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(REG_ARM):  rdata_o = DATA_W'(arm_q);
      ADDR_W'(REG_PEND): rdata_o = DATA_W'(pend_q);
      ADDR_W'(REG_SOCK): rdata_o = DATA_W'(sock_i);
      default:           rdata_o = '0;
    endcase
  end

  assign irq_o  = arm_q[ARM_GLB] & |(pend_q & arm_q[EVT_W-1:0]);
  assign arm_o  = arm_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/cdi_ctrl.sv
module cdi_ctrl
  import cdi_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              card_present_i,
  input  logic              card_busy_i,
  input  logic              card_ro_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic [SOCK_W-1:0] sock_raw, sock_s;
  evt_t              evt;
  logic [ARM_W-1:0]  arm_q;
  logic [EVT_W-1:0]  pend_q;

  always_comb begin
    sock_raw            = '0;
    sock_raw[SOCK_PRES] = card_present_i;
    sock_raw[SOCK_BUSY] = card_busy_i;
    sock_raw[SOCK_RO]   = card_ro_i;
  end

  cdi_sync #(.WIDTH(SOCK_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sock_raw), .q_o(sock_s)
  );

  cdi_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(sock_s[SOCK_PRES]), .evt_o(evt)
  );

  cdi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .evt_i(evt), .sock_i(sock_s),
    .arm_o(arm_q), .pend_o(pend_q),
    .rdata_o(reg_rdata_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/cdi_ctrl_chk.sv
module cdi_ctrl_chk
  import cdi_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic [ARM_W-1:0]  arm_q,
  input logic [EVT_W-1:0]  pend_q,
  input evt_t              evt
);
  // R3
  ins_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[0]) |-> $past(arm_q[ARM_INS]));
  // R4
  rem_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q[1]) |-> $past(arm_q[ARM_REM]));
  // R5
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(REG_PEND) && reg_wdata_i[0] && !evt.ins)
    |=> !pend_q[0]);
  // R2
  arm_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_i && reg_addr_i == ADDR_W'(REG_ARM)) |=> $stable(arm_q));
  // R9
  sock_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(REG_SOCK) && !evt.ins && !evt.rem)
    |=> ($stable(arm_q) && $stable(pend_q)));
  // R7
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q[ARM_GLB] |-> !irq_o);
endmodule

bind cdi_ctrl cdi_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .irq_o(irq_o), .arm_q(arm_q), .pend_q(pend_q),
  .evt(evt)
);

// File: tb/sim_cdi_ctrl.sv
`timescale 1ns/1ps
module sim_cdi_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       card_present_i = 1'b0, card_busy_i = 1'b0, card_ro_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;
  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  cdi_ctrl u0 (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #0.5 d = reg_rdata_o;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 arm", d, 0);
    rd(1, d); chk("R1 pend", d, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_arm_rb();
    logic [7:0] d;
    wr(0, 8'hFD); rd(0, d); chk("R2 readback", d, 8'h05);
    wr(1, 8'h00); rd(0, d); chk("R2 other addr", d, 8'h05);
    wr(0, 8'h00);
  endtask

  task automatic t_insert();
    logic [7:0] d;
    wr(0, 8'h05);
    @(negedge clk_i); card_present_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); reg_addr_i = 1; #0.5 chk("R11 edge1", reg_rdata_o, 0);
    @(posedge clk_i); @(negedge clk_i); #0.5 chk("R11 edge2", reg_rdata_o, 0);
    @(posedge clk_i); @(negedge clk_i); #0.5 chk("R3 insert set", reg_rdata_o, 1);
    chk("R7 irq on", irq_o, 1);
    wr(0, 8'h01); chk("R7 gate off", irq_o, 0);
    rd(1, d); chk("R7 pend kept", d, 1);
    wr(0, 8'h05); chk("R7 gate on", irq_o, 1);
    wr(1, 8'h02); rd(1, d); chk("R5 zero bit kept", d, 1);
    wr(1, 8'h01); rd(1, d); chk("R5 cleared", d, 0);
    chk("R5 irq low", irq_o, 0);
  endtask

  task automatic t_remove();
    logic [7:0] d;
    wr(0, 8'h06);
    @(negedge clk_i); card_present_i = 1'b0;
    settle();
    rd(1, d); chk("R4 remove set", d, 2);
    chk("R7 irq remove", irq_o, 1);
    wr(1, 8'h02);
  endtask

  task automatic t_unarmed();
    logic [7:0] d;
    wr(0, 8'h06);  // remove armed only; insert edge must be dropped
    @(negedge clk_i); card_present_i = 1'b1;
    settle();
    rd(1, d); chk("R3 unarmed insert", d, 0);
    chk("R3 irq", irq_o, 0);
    wr(0, 8'h05);  // insert armed only; remove edge must be dropped
    @(negedge clk_i); card_present_i = 1'b0;
    settle();
    rd(1, d); chk("R4 unarmed remove", d, 0);
  endtask

  task automatic t_set_wins();
    logic [7:0] d;
    wr(0, 8'h05);
    @(negedge clk_i); card_present_i = 1'b1;
    @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 1; reg_wdata_i = 8'h01;
    @(negedge clk_i); reg_we_i = 1'b0;
    rd(1, d); chk("R6 set wins", d, 1);
    wr(1, 8'h01);
  endtask

  task automatic t_socket();
    logic [7:0] d;
    @(negedge clk_i); card_busy_i = 1'b1; card_ro_i = 1'b0;
    settle(); rd(2, d); chk("R8 busy", d, 8'h03);
    @(negedge clk_i); card_busy_i = 1'b0; card_ro_i = 1'b1;
    settle(); rd(2, d); chk("R8 ro", d, 8'h05);
    wr(0, 8'h06);
    wr(2, 8'hFF);
    rd(0, d); chk("R9 arm kept", d, 8'h06);
    rd(1, d); chk("R9 pend kept", d, 0);
  endtask

  task automatic t_silence();
    logic [7:0] d;
    wr(0, 8'h06);
    @(negedge clk_i); card_present_i = 1'b0;
    settle();
    chk("R10 pre irq", irq_o, 1);
    wr(0, 8'h00); wr(1, 8'h03);
    rd(1, d); chk("R10 pend", d, 0);
    chk("R10 irq", irq_o, 0);
  endtask

  initial begin
    fork
      begin
        #3 chk("R1 irq in reset", irq_o, 0);
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset(); t_arm_rb(); t_insert(); t_remove(); t_unarmed();
        t_set_wins(); t_socket(); t_silence();
      end
      begin
        repeat (20000) @(posedge clk_i);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule